// File: doc/BRIEF.md
# SPI Command-Decoding Register Target

This block is an SPI target (clock idle low, data captured on the rising clock edge, changed on the falling edge, 8-bit bytes sent most significant bit first) that owns a byte-wide register space. An external host opens a transaction by pulling the select line low and sends an opcode byte. Depending on the opcode, it then sends an address and data, or a mask and data. Most commands have an address byte. Two kinds of short opcode carry none and jump straight to the first byte of a transmit or receive message buffer. An atomic masked update changes selected bits of one register in a single transaction.

The space holds a mode-request register and a mode-status register. Three bits of the request register select an operating mode. A fixed number of system clocks after the request is written, the status register reports that mode. The rest of the chip reads any register through a combinational side port and sees the active mode on a dedicated output.

The SPI pins are sampled by the system clock through a synchronizer, so the serial clock must run well below the system clock.

Top module: `scs_spi_regs`

## Requirements
- R1: A write transaction (opcode 0x02, then an address byte, then data) stores the data byte at that address. Bytes are 8 bits, MSB first, and MOSI is sampled on rising SCK.
- R2: A read transaction (opcode 0x03, then an address byte) drives the addressed register on MISO during the third byte, MSB first. MISO changes after falling SCK.
- R3: A bit-modify transaction (opcode 0x05, address, mask, data) sets each bit whose mask bit is 1 to the matching data bit and leaves the other bits unchanged.
- R4: In streaming write and read, the address advances by one after each data byte while select stays low, and wraps from 0x7F to 0x00.
- R5: Opcodes 0x40, 0x42 and 0x44 load transmit buffer 0, 1 and 2. The following bytes are written from address 0x31, 0x41 and 0x51, advancing as in R4.
- R6: Opcodes 0x90 and 0x94 read receive buffer 0 and 1. The byte after the opcode returns the register at 0x61 or 0x71, and later bytes continue upward.
- R7: After hardware reset, the status register (0x0E) reads 0x80, the mode-request register (0x0F) reads 0x87, every other register reads 0x00, and the current mode is 3'b100 (configuration).
- R8: Opcode 0xC0 returns every register to its R7 value, and the current mode to configuration, one clock after the opcode byte completes.
- R9: SPI writes and bit-modifies to the status register (0x0E) leave it unchanged.
- R10: Bits [7:5] of the request register encode the mode: 000 normal, 001 sleep, 010 loopback, 011 listen-only, 100 configuration. These bits are copied to status bits [7:5] and to cur_mode exactly four system clocks after the clock edge on which a write to the request register lands.
- R11: Raising select ends the transaction at any point. A partially shifted byte is discarded, and the next byte after select falls again is decoded as an opcode.
- R12: After an undefined opcode, every remaining byte of the transaction is ignored and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | SPI select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host; 0 when not selected |
| side_addr | input | ADDR_W | Side-port read address |
| side_rdata | output | 8 | Register value at side_addr (combinational) |
| cur_mode | output | 3 | Active operating mode (status bits [7:5]) |

## Verification
The assertions assume that each SCK level and each select transition lasts long enough to pass the synchronizer before the next edge. The assertions also assume that select only changes while SCK is low. The bench holds every SCK half period at eight system clocks, changes select only with SCK low, and leaves several clocks of idle time between transactions.

The masked-update and status-protection properties assume that write requests reach the register file one per byte. They therefore only check the cycle after a write. The mode-delay check starts from the cycle in which the request register visibly changes on the side port. This lets the four-clock window be counted without knowing the synchronizer latency.

// File: rtl/scs_pkg.sv
package scs_pkg;

   // command opcodes
   localparam logic [7:0] OP_WRITE  = 8'h02;
   localparam logic [7:0] OP_READ   = 8'h03;
   localparam logic [7:0] OP_BITMOD = 8'h05;
   localparam logic [7:0] OP_RESET  = 8'hC0;
   // short buffer opcodes: upper five bits fixed, buffer index in low bits
   localparam logic [4:0] OP_TXLD_HI = 5'b01000;
   localparam logic [4:0] OP_RXRD_HI = 5'b10010;

   // operating mode codes
   localparam logic [2:0] MODE_NORMAL = 3'b000;
   localparam logic [2:0] MODE_SLEEP  = 3'b001;
   localparam logic [2:0] MODE_LOOP   = 3'b010;
   localparam logic [2:0] MODE_LISTEN = 3'b011;
   localparam logic [2:0] MODE_CFG    = 3'b100;

   // decoder states
   typedef enum logic [2:0] {
      ST_OPC,
      ST_ADR,
      ST_MSK,
      ST_BMD,
      ST_WR,
      ST_RD,
      ST_SKIP
   } dec_state_t;

   typedef enum logic [1:0] {
      CMD_WR,
      CMD_RD,
      CMD_BM
   } cmd_t;

endpackage

// File: rtl/scs_sampler.sv
module scs_sampler #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic mosi,
   output logic sck_rise,
   output logic sck_fall,
   output logic cs_act,
   output logic mosi_s
);
   localparam int          W       = 3 * STAGES;
   localparam logic [2:0]  IDLE3   = 3'b010;       // {mosi, cs_n, sck}

   if (STAGES < 1) begin : g_bad_stages
      $error("scs_sampler: STAGES must be at least 1");
   end

   logic [W-1:0] chain;
   logic [2:0]   last;
   logic         sck_d;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= IDLE3;
         else        chain <= {mosi, cs_n, sck};
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{IDLE3}};
         else        chain <= {chain[W-4:0], mosi, cs_n, sck};
      end
   end

   assign last = chain[W-1 -: 3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= last[0];
   end

   assign sck_rise = last[0] & ~sck_d;
   assign sck_fall = ~last[0] & sck_d;
   assign cs_act   = ~last[1];
   assign mosi_s   = last[2];

endmodule

// File: rtl/scs_shifter.sv
module scs_shifter (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sck_rise,
   input  logic       sck_fall,
   input  logic       cs_act,
   input  logic       mosi_s,
   input  logic       load,
   input  logic [7:0] load_data,
   output logic       byte_done,
   output logic [7:0] rx_byte,
   output logic       miso
);
   logic [2:0] bitcnt;
   logic [7:0] rxsh;
   logic [7:0] txsh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bitcnt    <= '0;
         rxsh      <= '0;
         txsh      <= '0;
         byte_done <= 1'b0;
         rx_byte   <= '0;
      end else begin
         byte_done <= 1'b0;
         if (!cs_act) begin
            bitcnt <= '0;
            txsh   <= '0;
         end else begin
            if (sck_rise) begin
               rxsh   <= {rxsh[6:0], mosi_s};
               bitcnt <= bitcnt + 3'd1;
               if (bitcnt == 3'd7) begin
                  byte_done <= 1'b1;
                  rx_byte   <= {rxsh[6:0], mosi_s};
               end
            end
            if (load)
               txsh <= load_data;
            else if (sck_fall && bitcnt != 3'd0)
               txsh <= {txsh[6:0], 1'b0};
         end
      end
   end

   assign miso = cs_act & txsh[7];

   // R11: a deselect always leaves the bit counter cleared
   p_abort_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (bitcnt == 3'd0));

endmodule

// File: rtl/scs_regfile.sv
module scs_regfile
   import scs_pkg::*;
#(
   parameter int         ADDR_W     = 7,
   parameter int         MODE_DELAY = 4,
   parameter int         STAT_ADDR  = 'h0E,
   parameter int         CTRL_ADDR  = 'h0F,
   parameter logic [7:0] STAT_RST   = 8'h80,
   parameter logic [7:0] CTRL_RST   = 8'h87
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [7:0]        wdata,
   input  logic [7:0]        wmask,
   input  logic [ADDR_W-1:0] raddr,
   output logic [7:0]        rdata,
   input  logic [ADDR_W-1:0] side_addr,
   output logic [7:0]        side_rdata,
   output logic [2:0]        cur_mode
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int CNT_W = $clog2(MODE_DELAY + 1);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

   if (MODE_DELAY < 1) begin : g_bad_delay
      $error("scs_regfile: MODE_DELAY must be at least 1");
   end
   if (STAT_ADDR == CTRL_ADDR || STAT_ADDR >= DEPTH || CTRL_ADDR >= DEPTH) begin : g_bad_addr
      $error("scs_regfile: mode register addresses invalid");
   end

   logic [7:0]       mem [DEPTH];
   logic [CNT_W-1:0] cnt;

   function automatic logic [7:0] rst_val(input int a);
      if (a == STAT_ADDR)      return STAT_RST;
      else if (a == CTRL_ADDR) return CTRL_RST;
      else                     return 8'h00;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= rst_val(i);
         cnt <= '0;
      end else if (soft_rst) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= rst_val(i);
         cnt <= '0;
      end else begin
         if (we && waddr != STAT_A)
            mem[waddr] <= (mem[waddr] & ~wmask) | (wdata & wmask);
         if (cnt == CNT_W'(1))
            mem[STAT_A][7:5] <= mem[CTRL_A][7:5];
         if (we && waddr == CTRL_A)
            cnt <= CNT_W'(MODE_DELAY);
         else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
      end
   end

   assign rdata      = mem[raddr];
   assign side_rdata = mem[side_addr];
   assign cur_mode   = mem[STAT_A][7:5];

   // checker capture of the previous write
   logic [ADDR_W-1:0] chk_addr;
   logic [7:0]        chk_mask;
   logic [7:0]        chk_old;
   always_ff @(posedge clk) begin
      chk_addr <= waddr;
      chk_mask <= wmask;
      chk_old  <= mem[waddr];
   end

   // R3: bits outside the mask keep their value
   p_mask_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !soft_rst && waddr != STAT_A) |=>
         ((mem[chk_addr] & ~chk_mask) == (chk_old & ~chk_mask)));

   // R9: status register not writable over SPI
   p_stat_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == STAT_A && !soft_rst && cnt != CNT_W'(1)) |=> $stable(mem[STAT_A]));

   // R10: status mode follows the request when the delay expires
   p_mode_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_W'(1) && !soft_rst) |=> (cur_mode == $past(mem[CTRL_A][7:5])));

   // R8: reset opcode returns to configuration mode
   p_reset_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (cur_mode == MODE_CFG && mem[CTRL_A] == CTRL_RST));

endmodule

// File: rtl/scs_spi_regs.sv
module scs_spi_regs
   import scs_pkg::*;
#(
   parameter int         ADDR_W      = 7,
   parameter int         SYNC_STAGES = 2,
   parameter int         MODE_DELAY  = 4,
   parameter int         STAT_ADDR   = 'h0E,
   parameter int         CTRL_ADDR   = 'h0F,
   parameter logic [7:0] STAT_RST    = 8'h80,
   parameter logic [7:0] CTRL_RST    = 8'h87,
   parameter int         TXB_BASE    = 'h30,
   parameter int         RXB_BASE    = 'h60,
   parameter int         BUF_STRIDE  = 'h10,
   parameter int         NUM_TXB     = 3,
   parameter int         NUM_RXB     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              cs_n,
   input  logic              mosi,
   output logic              miso,
   input  logic [ADDR_W-1:0] side_addr,
   output logic [7:0]        side_rdata,
   output logic [2:0]        cur_mode
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 7 || ADDR_W > 8) begin : g_bad_aw
      $error("scs_spi_regs: ADDR_W must be 7 or 8");
   end
   if (NUM_TXB < 1 || NUM_TXB > 3 || NUM_RXB < 1 || NUM_RXB > 2) begin : g_bad_nbuf
      $error("scs_spi_regs: buffer counts out of range");
   end
   if (TXB_BASE + BUF_STRIDE * NUM_TXB > DEPTH ||
       RXB_BASE + BUF_STRIDE * NUM_RXB > DEPTH) begin : g_bad_base
      $error("scs_spi_regs: buffer window exceeds register space");
   end

   logic sck_rise, sck_fall, cs_act, mosi_s;
   logic byte_done;
   logic [7:0] rx_byte;
   logic load;
   logic [7:0] rdata;

   dec_state_t        state;
   cmd_t              cmd;
   logic [ADDR_W-1:0] ptr;
   logic [7:0]        mask_q;

   logic              we, soft_rst;
   logic [ADDR_W-1:0] waddr, rd_addr;
   logic [7:0]        wdata, wmask;

   // opcode classification
   logic              is_txld, is_rxrd;
   logic [ADDR_W-1:0] txb_start, rxb_start;

   always_comb begin
      is_txld   = (rx_byte[7:3] == OP_TXLD_HI) && !rx_byte[0] &&
                  (int'(rx_byte[2:1]) < NUM_TXB);
      is_rxrd   = (rx_byte[7:3] == OP_RXRD_HI) && (rx_byte[1:0] == 2'b00) &&
                  (int'(rx_byte[2]) < NUM_RXB);
      txb_start = ADDR_W'(TXB_BASE + BUF_STRIDE * int'(rx_byte[2:1]) + 1);
      rxb_start = ADDR_W'(RXB_BASE + BUF_STRIDE * int'(rx_byte[2]) + 1);
   end

   scs_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck      (sck),
      .cs_n     (cs_n),
      .mosi     (mosi),
      .sck_rise (sck_rise),
      .sck_fall (sck_fall),
      .cs_act   (cs_act),
      .mosi_s   (mosi_s)
   );

   scs_shifter u_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck_rise  (sck_rise),
      .sck_fall  (sck_fall),
      .cs_act    (cs_act),
      .mosi_s    (mosi_s),
      .load      (load),
      .load_data (rdata),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .miso      (miso)
   );

   scs_regfile #(
      .ADDR_W     (ADDR_W),
      .MODE_DELAY (MODE_DELAY),
      .STAT_ADDR  (STAT_ADDR),
      .CTRL_ADDR  (CTRL_ADDR),
      .STAT_RST   (STAT_RST),
      .CTRL_RST   (CTRL_RST)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (soft_rst),
      .we         (we),
      .waddr      (waddr),
      .wdata      (wdata),
      .wmask      (wmask),
      .raddr      (rd_addr),
      .rdata      (rdata),
      .side_addr  (side_addr),
      .side_rdata (side_rdata),
      .cur_mode   (cur_mode)
   );

   // per-byte actions
   always_comb begin
      we       = 1'b0;
      soft_rst = 1'b0;
      load     = 1'b0;
      waddr    = ptr;
      wdata    = rx_byte;
      wmask    = 8'hFF;
      rd_addr  = ptr;
      if (byte_done && cs_act) begin
         unique case (state)
            ST_OPC: begin
               if (rx_byte == OP_RESET) soft_rst = 1'b1;
               if (is_rxrd) begin
                  rd_addr = rxb_start;
                  load    = 1'b1;
               end
            end
            ST_ADR: begin
               if (cmd == CMD_RD) begin
                  rd_addr = rx_byte[ADDR_W-1:0];
                  load    = 1'b1;
               end
            end
            ST_BMD: begin
               we    = 1'b1;
               wmask = mask_q;
            end
            ST_WR:  we   = 1'b1;
            ST_RD:  load = 1'b1;
            default: ;
         endcase
      end
   end

   // command sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_OPC;
         cmd    <= CMD_WR;
         ptr    <= '0;
         mask_q <= '0;
      end else if (!cs_act) begin
         state <= ST_OPC;
      end else if (byte_done) begin
         unique case (state)
            ST_OPC: begin
               if (rx_byte == OP_WRITE) begin
                  cmd <= CMD_WR;  state <= ST_ADR;
               end else if (rx_byte == OP_READ) begin
                  cmd <= CMD_RD;  state <= ST_ADR;
               end else if (rx_byte == OP_BITMOD) begin
                  cmd <= CMD_BM;  state <= ST_ADR;
               end else if (is_txld) begin
                  ptr <= txb_start;  state <= ST_WR;
               end else if (is_rxrd) begin
                  ptr <= rxb_start + ADDR_W'(1);  state <= ST_RD;
               end else begin
                  state <= ST_SKIP;
               end
            end
            ST_ADR: begin
               unique case (cmd)
                  CMD_RD: begin
                     ptr   <= rx_byte[ADDR_W-1:0] + ADDR_W'(1);
                     state <= ST_RD;
                  end
                  CMD_BM: begin
                     ptr   <= rx_byte[ADDR_W-1:0];
                     state <= ST_MSK;
                  end
                  default: begin
                     ptr   <= rx_byte[ADDR_W-1:0];
                     state <= ST_WR;
                  end
               endcase
            end
            ST_MSK: begin
               mask_q <= rx_byte;
               state  <= ST_BMD;
            end
            ST_BMD: state <= ST_SKIP;
            ST_WR,
            ST_RD:  ptr <= ptr + ADDR_W'(1);
            default: ;
         endcase
      end
   end

   // R4: streaming address wraps from the top of the space to zero
   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && cs_act && (state == ST_WR || state == ST_RD) && ptr == '1)
         |=> (ptr == '0));

   // R11: deselect returns the decoder to opcode state
   p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (state == ST_OPC));

   // R12: an unknown opcode never produces a register write
   p_skip_nowrite_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> !we);

endmodule

// File: tb/scs_spi_regs_tb.sv
module scs_spi_regs_tb;
   localparam int ADDR_W = 7;
   localparam int HP     = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sck = 1'b0;
   logic              cs_n = 1'b1;
   logic              mosi = 1'b0;
   logic              miso;
   logic [ADDR_W-1:0] side_addr = '0;
   logic [7:0]        side_rdata;
   logic [2:0]        cur_mode;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   scs_spi_regs u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .sck        (sck),
      .cs_n       (cs_n),
      .mosi       (mosi),
      .miso       (miso),
      .side_addr  (side_addr),
      .side_rdata (side_rdata),
      .cur_mode   (cur_mode)
   );

   // {op, addr, mask, data, expected}
   localparam logic [39:0] VECS [8] = '{
      40'h02_20_FF_A5_A5,
      40'h02_21_FF_5A_5A,
      40'h05_20_F0_3C_35,
      40'h05_21_00_FF_5A,
      40'h05_21_FF_81_81,
      40'h02_0E_FF_00_80,
      40'h02_7F_FF_11_11,
      40'h05_00_0F_FF_0F
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cs_on();
      cs_n = 1'b0;
      wait_clk(HP);
   endtask

   task automatic cs_off();
      wait_clk(HP);
      cs_n = 1'b1;
      wait_clk(4 * HP);
   endtask

   task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
      rx = '0;
      for (int i = 7; i > 7 - nb; i--) begin
         mosi = tx[i];
         wait_clk(HP);
         rx[i] = miso;
         sck = 1'b1;
         wait_clk(HP);
         sck = 1'b0;
      end
   endtask

   task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
      spi_bits(tx, 8, rx);
   endtask

   task automatic cmd_write1(input logic [7:0] a, input logic [7:0] d);
      logic [7:0] r;
      cs_on();
      spi_byte(8'h02, r);
      spi_byte(a, r);
      spi_byte(d, r);
      cs_off();
   endtask

   task automatic cmd_bitmod(input logic [7:0] a, input logic [7:0] m, input logic [7:0] d);
      logic [7:0] r;
      cs_on();
      spi_byte(8'h05, r);
      spi_byte(a, r);
      spi_byte(m, r);
      spi_byte(d, r);
      cs_off();
   endtask

   task automatic cmd_read1(input logic [7:0] a, output logic [7:0] v);
      logic [7:0] r;
      cs_on();
      spi_byte(8'h03, r);
      spi_byte(a, r);
      spi_byte(8'h00, v);
      cs_off();
   endtask

   task automatic side_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
      side_addr = a[ADDR_W-1:0];
      wait_clk(1);
      check(tag, side_rdata, exp);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [7:0] r, r1, r2;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);

      // R7: reset values
      side_chk("R7 status", 8'h0E, 8'h80);
      side_chk("R7 request", 8'h0F, 8'h87);
      side_chk("R7 other", 8'h45, 8'h00);
      check("R7 mode", {5'd0, cur_mode}, 8'h04);
      check("R7 miso idle", {7'd0, miso}, 8'h00);
      cmd_read1(8'h0E, r);
      check("R2 R7 status read", r & 8'hEE, 8'h80);
      cmd_read1(8'h0F, r);
      check("R2 R7 request read", r & 8'h17, 8'h07);

      // table walk: R1 writes, R3 bit modify, R9 status protect
      for (int k = 0; k < 8; k++) begin
         logic [7:0] op, a, m, d, e;
         string tag;
         {op, a, m, d, e} = VECS[k];
         if (a == 8'h0E)      tag = "R9";
         else if (op == 8'h05) tag = "R3";
         else                  tag = "R1";
         if (op == 8'h05) cmd_bitmod(a, m, d);
         else             cmd_write1(a, d);
         cmd_read1(a, r);
         check({tag, " R2 spi"}, r, e);
         side_chk({tag, " side"}, a, e);
      end

      // R4: stream write across the wrap, then stream read
      cs_on();
      spi_byte(8'h02, r);
      spi_byte(8'h7E, r);
      spi_byte(8'hB1, r);
      spi_byte(8'hB2, r);
      spi_byte(8'hB3, r);
      cs_off();
      side_chk("R4 7E", 8'h7E, 8'hB1);
      side_chk("R4 7F", 8'h7F, 8'hB2);
      side_chk("R4 wrap 00", 8'h00, 8'hB3);
      cs_on();
      spi_byte(8'h03, r);
      spi_byte(8'h7F, r);
      spi_byte(8'h00, r1);
      spi_byte(8'h00, r2);
      cs_off();
      check("R4 read 7F", r1, 8'hB2);
      check("R4 read wrap", r2, 8'hB3);

      // R5: transmit buffer loads
      cs_on();
      spi_byte(8'h42, r);
      spi_byte(8'h12, r);
      spi_byte(8'h34, r);
      cs_off();
      side_chk("R5 buf1 first", 8'h41, 8'h12);
      side_chk("R5 buf1 next", 8'h42, 8'h34);
      cs_on();
      spi_byte(8'h40, r);
      spi_byte(8'h9A, r);
      cs_off();
      side_chk("R5 buf0", 8'h31, 8'h9A);
      cs_on();
      spi_byte(8'h44, r);
      spi_byte(8'h5C, r);
      cs_off();
      side_chk("R5 buf2", 8'h51, 8'h5C);

      // R6: receive buffer reads
      cs_on();
      spi_byte(8'h02, r);
      spi_byte(8'h61, r);
      spi_byte(8'hC1, r);
      spi_byte(8'hC2, r);
      cs_off();
      cmd_write1(8'h71, 8'hD7);
      cs_on();
      spi_byte(8'h90, r);
      spi_byte(8'h00, r1);
      spi_byte(8'h00, r2);
      cs_off();
      check("R6 rx0 first", r1, 8'hC1);
      check("R6 rx0 next", r2, 8'hC2);
      cs_on();
      spi_byte(8'h94, r);
      spi_byte(8'h00, r1);
      cs_off();
      check("R6 rx1 first", r1, 8'hD7);

      // R10: mode request to loopback, exact delay
      side_addr = 7'h0F;
      fork
         cmd_write1(8'h0F, 8'h47);
         begin
            while (side_rdata !== 8'h47) wait_clk(1);
            wait_clk(3);
            check("R10 before delay", {5'd0, cur_mode}, 8'h04);
            wait_clk(1);
            check("R10 after delay", {5'd0, cur_mode}, 8'h02);
         end
      join
      cmd_read1(8'h0E, r);
      check("R10 status read", r & 8'hE0, 8'h40);

      // R8: reset opcode
      cs_on();
      spi_byte(8'hC0, r);
      cs_off();
      check("R8 mode", {5'd0, cur_mode}, 8'h04);
      side_chk("R8 request", 8'h0F, 8'h87);
      side_chk("R8 status", 8'h0E, 8'h80);
      side_chk("R8 cleared", 8'h20, 8'h00);

      // R11: abort mid-byte
      cs_on();
      spi_byte(8'h02, r);
      spi_byte(8'h30, r);
      spi_bits(8'hFF, 4, r);
      cs_off();
      side_chk("R11 partial dropped", 8'h30, 8'h00);
      cs_on();
      spi_bits(8'h05, 5, r);
      cs_off();
      cmd_write1(8'h30, 8'h66);
      side_chk("R11 fresh opcode", 8'h30, 8'h66);

      // R12: unknown opcode swallows the rest
      cs_on();
      spi_byte(8'h11, r);
      spi_byte(8'h02, r);
      spi_byte(8'h30, r);
      spi_byte(8'h77, r);
      cs_off();
      side_chk("R12 ignored", 8'h30, 8'h66);
      side_chk("R12 addr ignored", 8'h02, 8'h00);

      finish_run();
   end

endmodule